// File: doc/BRIEF.md
# Command Response Word Packer

This block sits behind the receiver that captures a card's reply to a command. It takes the reply one byte at a time and builds 16-bit words from it, with the earlier byte in the upper half of each word. The finished words go into a small first-in first-out store, and the processor empties that store through a read-only data register. A three-bit format code chooses which part of the reply is kept: a short reply keeps its first six bytes, a long reply drops its leading byte and keeps the next sixteen, and the "no reply" code keeps nothing.

Every new command first empties the store, so words left over from an earlier reply can never be read as part of the next one. When the last byte of a reply has been taken, a one-cycle end pulse marks the moment at which every word of that reply is counted in the level output. Format codes with no defined meaning store nothing, and a flag pulses together with the end pulse. Taking bits off the card line and checking the CRC are done elsewhere.

Top module: `rsp_fifo_packer`

## Requirements
- R1: Format code 0 stores no word. The end pulse still follows the last byte.
- R2: Format codes 1 and 3 keep reply bytes 0 to 5 as three words. Byte 2k goes to bits 15:8 of word k and byte 2k+1 to bits 7:0. Later bytes are dropped.
- R3: Format code 2 keeps reply bytes 1 to 16 as eight words. Byte 1+2k goes to bits 15:8 of word k and byte 2+2k to bits 7:0. Byte 0 and any byte after 16 are dropped. An unpaired final byte of the window stores nothing.
- R4: The store holds 8 words. `level_o` gives the count, from 0 to 8. `rd_data_o` shows the oldest word while the store is not empty, and a read strobe removes that word.
- R5: `cmd_new_i` sets the level to 0 in the next cycle and restarts the byte count with the next byte. A byte or a read strobe given in the same cycle as `cmd_new_i` has no effect.
- R6: A read strobe while the store is empty leaves the read position and the level unchanged. `rd_data_o` keeps showing the entry at that position, which is the slot that will be read next.
- R7: `cmd_end_o` is high for exactly one cycle. That cycle is the one after the edge that takes the byte flagged last, and in it `level_o` already counts every word of the reply. Bytes that follow, up to the next `cmd_new_i`, are ignored.
- R8: Format codes 4 to 7 store no word. `fmt_err_o` is high in the same cycle as `cmd_end_o` and is low at all other times.
- R9: A read strobe in the same cycle as a word completing, while the store is not empty, removes one word and stores one word, so the level stays the same.
- R10: Bytes that arrive before the first `cmd_new_i` after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_new_i | input | 1 | A new command is issued: empty the store and capture the format |
| rsp_fmt_i | input | 3 | Reply format code, taken while `cmd_new_i` is high |
| rsp_byte_i | input | 8 | Reply byte |
| rsp_valid_i | input | 1 | `rsp_byte_i` holds a byte this cycle |
| rsp_last_i | input | 1 | This byte is the last byte of the reply |
| rd_en_i | input | 1 | Read strobe for the data register |
| rd_data_o | output | 16 | Word at the read position |
| level_o | output | 4 | Number of stored words |
| cmd_end_o | output | 1 | One-cycle pulse: the reply is complete and stored |
| fmt_err_o | output | 1 | Pulses with `cmd_end_o` when the format code is illegal |

## Verification
Two sets of events can fall in the same cycle. The first is the processor reading while the packer completes a word. The bench provokes it by raising the read strobe on the same edge as the fourth reply byte, with one word already stored, and it then expects the level to stay at one and the next word to appear. The second is a new command arriving together with a read strobe and a reply byte. Here the bench expects the store to be empty afterwards, and it checks that the first word of the next reply begins with that reply's own byte 0. The stray byte must not shift it.

// File: rtl/rspf_pkg.sv
package rspf_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 5;

  localparam logic [2:0] FMT_NONE    = 3'd0;
  localparam logic [2:0] FMT_SHORT_A = 3'd1;
  localparam logic [2:0] FMT_LONG    = 3'd2;
  localparam logic [2:0] FMT_SHORT_B = 3'd3;

  // Byte window that a format keeps: first index and number of bytes.
  typedef struct packed {
    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] count;
  } win_t;

  function automatic win_t fmt_window(input logic [2:0] fmt);
    win_t w;
    case (fmt)
      FMT_SHORT_A, FMT_SHORT_B: begin w.first = 5'd0; w.count = 5'd6;  end
      FMT_LONG:                 begin w.first = 5'd1; w.count = 5'd16; end
      default:                  begin w.first = 5'd0; w.count = 5'd0;  end
    endcase
    return w;
  endfunction

  function automatic logic fmt_legal(input logic [2:0] fmt);
    return (fmt <= FMT_SHORT_B);
  endfunction

endpackage

// File: rtl/rspf_pack.sv
module rspf_pack
  import rspf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        fmt_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic              word_we_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic              busy_q, busy_d;
  logic [2:0]        fmt_q, fmt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  win_t             win;
  logic             take;
  logic [IDX_W-1:0] rel;
  logic             in_win;

  always_comb begin
    win    = fmt_window(fmt_q);
    take   = valid_i && busy_q && !start_i;
    rel    = idx_q - win.first;
    in_win = take && (idx_q >= win.first) && (rel < win.count);
  end

  assign word_we_o = in_win && rel[0];
  assign word_o    = {hi_q, byte_i};
  assign done_o    = done_q;
  assign err_o     = err_q;

  // Next-state process
  always_comb begin
    busy_d = busy_q;
    fmt_d  = fmt_q;
    idx_d  = idx_q;
    hi_d   = hi_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      fmt_d  = fmt_i;
      idx_d  = '0;
    end else if (take) begin
      idx_d = (idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1;
      if (in_win && !rel[0]) hi_d = byte_i;
      if (last_i) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        err_d  = !fmt_legal(fmt_q);
      end
    end
  end

  // Register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fmt_q  <= FMT_NONE;
      idx_q  <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fmt_q  <= fmt_d;
      idx_q  <= idx_d;
      hi_q   <= hi_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  AST_NONE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_NONE) |-> !word_we_o);  // R1
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fmt_legal(fmt_q) |-> !word_we_o);  // R8
  AST_END_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_ERR_WITH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);  // R8

endmodule

// File: rtl/rspf_fifo.sv
module rspf_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   we_i,
  input  logic [WORD_W-1:0]      wdata_i,
  input  logic                   rd_i,
  output logic [WORD_W-1:0]      rdata_o,
  output logic [$clog2(DEPTH):0] level_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL_LVL = PTR_W'(DEPTH) | ((PTR_W+1)'(DEPTH));

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]    wp_q, wp_d, rp_q, rp_d;
  logic [PTR_W:0]    level;
  logic              push, pop;

  always_comb begin
    level = wp_q - rp_q;
    push  = we_i && !flush_i && (level != FULL_LVL);
    pop   = rd_i && !flush_i && (level != '0);
  end

  assign level_o = level;
  assign rdata_o = mem_q[rp_q[PTR_W-1:0]];

  // Next-state process
  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push) wp_d = wp_q + 1'b1;
    if (flush_i)  rp_d = wp_q;
    else if (pop) rp_d = rp_q + 1'b1;
  end

  // Register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  // Storage: written only on push, no reset
  always_ff @(posedge clk_i) begin
    if (push) mem_q[wp_q[PTR_W-1:0]] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL_LVL);  // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0));  // R5
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !we_i && !flush_i && level_o == '0) |=> (level_o == '0) && $stable(rdata_o));  // R6
  AST_READ_WRITE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && we_i && !flush_i && level_o != '0) |=> $stable(level_o));  // R9

endmodule

// File: rtl/rsp_fifo_packer.sv
module rsp_fifo_packer #(
  parameter int DEPTH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_new_i,
  input  logic [2:0]             rsp_fmt_i,
  input  logic [7:0]             rsp_byte_i,
  input  logic                   rsp_valid_i,
  input  logic                   rsp_last_i,
  input  logic                   rd_en_i,
  output logic [15:0]            rd_data_o,
  output logic [$clog2(DEPTH):0] level_o,
  output logic                   cmd_end_o,
  output logic                   fmt_err_o
);

  localparam int WORD_W = 2 * rspf_pkg::BYTE_W;

  logic [WORD_W-1:0] word;
  logic              word_we;

  rspf_pack u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cmd_new_i),
    .fmt_i     (rsp_fmt_i),
    .byte_i    (rsp_byte_i),
    .valid_i   (rsp_valid_i),
    .last_i    (rsp_last_i),
    .word_o    (word),
    .word_we_o (word_we),
    .done_o    (cmd_end_o),
    .err_o     (fmt_err_o)
  );

  rspf_fifo #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cmd_new_i),
    .we_i    (word_we),
    .wdata_i (word),
    .rd_i    (rd_en_i),
    .rdata_o (rd_data_o),
    .level_o (level_o)
  );

  AST_NEW_CMD_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_new_i |=> !cmd_end_o);  // R5

endmodule

// File: tb/rsp_fifo_packer_bench.sv
module rsp_fifo_packer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_new, valid, last, rd;
  logic [2:0]  fmt;
  logic [7:0]  bval;
  logic [15:0] rdata;
  logic [3:0]  level;
  logic        cmd_end, ferr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rsp_fifo_packer u_rsp_fifo_packer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_new_i(cmd_new), .rsp_fmt_i(fmt),
    .rsp_byte_i(bval), .rsp_valid_i(valid), .rsp_last_i(last), .rd_en_i(rd),
    .rd_data_o(rdata), .level_o(level), .cmd_end_o(cmd_end), .fmt_err_o(ferr)
  );

  // {format, reply length, expected words}
  localparam logic [11:0] VEC [0:7] = '{
    {3'd1, 5'd6,  4'd3}, {3'd3, 5'd8,  4'd3}, {3'd2, 5'd17, 4'd8},
    {3'd2, 5'd20, 4'd8}, {3'd0, 5'd6,  4'd0}, {3'd5, 5'd10, 4'd0},
    {3'd2, 5'd10, 4'd4}, {3'd1, 5'd4,  4'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; returns at the next negedge.
  task automatic drive(input logic c, input logic [2:0] f, input logic [7:0] b,
                       input logic v, input logic l, input logic r);
    cmd_new = c; fmt = f; bval = b; valid = v; last = l; rd = r;
    @(negedge clk);
    cmd_new = 0; valid = 0; last = 0; rd = 0;
  endtask

  task automatic send_resp(input logic [2:0] f, input int len, input logic [7:0] seed);
    drive(1, f, 8'h00, 0, 0, 0);
    for (int i = 0; i < len; i++) drive(0, f, seed + 8'(i), 1, (i == len - 1), 0);
  endtask

  function automatic logic [15:0] exp_word(input logic [2:0] f, input logic [7:0] seed, input int k);
    logic [7:0] first;
    first = (f == 3'd2) ? 8'd1 : 8'd0;
    return {seed + first + 8'(2*k), seed + first + 8'(2*k + 1)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cmd_new = 0; fmt = 0; bval = 0; valid = 0; last = 0; rd = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset level", int'(level), 0);
    chk("R7 reset cmd_end", int'(cmd_end), 0);
    chk("R8 reset fmt_err", int'(ferr), 0);

    // R10: bytes before any command
    drive(0, 3'd1, 8'h11, 1, 0, 0);
    drive(0, 3'd1, 8'h12, 1, 1, 0);
    chk("R10 pre-command level", int'(level), 0);
    chk("R10 pre-command cmd_end", int'(cmd_end), 0);

    // Table of replies
    for (int v = 0; v < 8; v++) begin
      logic [2:0] f;
      int         n, w;
      logic [7:0] seed;
      string      req;
      f = VEC[v][11:9]; n = int'(VEC[v][8:4]); w = int'(VEC[v][3:0]);
      seed = 8'(16 * (v + 1));
      req = (f == 0) ? "R1" : (f == 2) ? "R3" : (f > 3) ? "R8" : "R2";
      send_resp(f, n, seed);
      chk({"R7 end pulse ", req}, int'(cmd_end), 1);
      chk({req, " level"}, int'(level), w);
      chk({"R8 flag ", req}, int'(ferr), int'(f > 3));
      for (int k = 0; k < w; k++) begin
        chk({req, " word"}, int'(rdata), int'(exp_word(f, seed, k)));
        drive(0, f, 8'h00, 0, 0, 1);
        chk("R7 end low", int'(cmd_end), 0);
      end
      chk("R4 drained", int'(level), 0);
    end

    // R6: fill all 8 slots, drain, then read while empty
    send_resp(3'd2, 17, 8'h40);
    for (int k = 0; k < 8; k++) drive(0, 3'd2, 8'h00, 0, 0, 1);
    chk("R6 empty shows slot", int'(rdata), int'(exp_word(3'd2, 8'h40, 0)));
    drive(0, 3'd2, 8'h00, 0, 0, 1);
    chk("R6 empty read level", int'(level), 0);
    chk("R6 empty read data", int'(rdata), int'(exp_word(3'd2, 8'h40, 0)));

    // R9: read on the same edge as a word completes
    drive(1, 3'd1, 8'h00, 0, 0, 0);
    drive(0, 3'd1, 8'h60, 1, 0, 0);
    drive(0, 3'd1, 8'h61, 1, 0, 0);
    chk("R9 one word", int'(level), 1);
    drive(0, 3'd1, 8'h62, 1, 0, 0);
    drive(0, 3'd1, 8'h63, 1, 0, 1);
    chk("R9 level held", int'(level), 1);
    chk("R9 next word", int'(rdata), 16'h6263);
    drive(0, 3'd1, 8'h64, 1, 0, 0);
    drive(0, 3'd1, 8'h65, 1, 1, 0);
    chk("R9 final level", int'(level), 2);

    // R5: new command with a read and a byte in the same cycle
    cmd_new = 1; fmt = 3'd1; bval = 8'hEE; valid = 1; rd = 1;
    @(negedge clk);
    cmd_new = 0; valid = 0; rd = 0;
    chk("R5 flushed", int'(level), 0);
    for (int i = 0; i < 6; i++) drive(0, 3'd1, 8'h80 + 8'(i), 1, (i == 5), 0);
    chk("R5 level after flush", int'(level), 3);
    // R7: bytes after the last one are ignored
    drive(0, 3'd1, 8'h90, 1, 0, 0);
    drive(0, 3'd1, 8'h91, 1, 1, 0);
    chk("R7 trailing bytes level", int'(level), 3);
    chk("R7 trailing bytes end", int'(cmd_end), 0);
    chk("R5 fresh byte count", int'(rdata), 16'h8081);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule